// File: doc/BRIEF.md
# Single-Wire Return-to-One Serial Slave

This block is the slave end of a one-wire, open-drain, asynchronous serial bus. Every bit is coded by the width of a low pulse that starts at a falling edge. A host uses the bus to reach a 128-entry byte register space that sits beside the block. The host first sends a long low break and then a short high recovery. After that it sends a command byte, least-significant bit first. Bit 7 of the command selects the direction and bits 6:0 give the register address. A write command is followed by one data byte from the host. A read command is answered by the slave, which pulls the wire low to send the addressed byte back in the same pulse-width code.

All timing is counted in ticks of a one-microsecond strobe that comes from the surrounding clock domain. The bus input passes through a synchroniser before any edge is detected. The register side is a plain port: an address, a write strobe with its data, and a read-data input that is sampled at the moment the reply starts. The register file decides the read value. The block applies a per-address writable mask before it raises the write strobe.

Top module: `owire_slave`

## Requirements
- R1: After reset, no command is accepted until a break and a full recovery have been seen: a write sent before that gives no `reg_we`, and a read sent before that gives no reply.
- R2: A break is a low of at least 190 µs. At least 40 µs of high must follow before a command is accepted. A falling edge that comes earlier in the recovery makes the block wait for a new break.
- R3: A received bit is the bus level 70 µs after its falling edge: a low held past that point is 0, and a low released earlier is 1. Bytes arrive least-significant bit first.
- R4: A command with bit 7 = 1 writes the next received byte to the address in bits 6:0. The write is a one-cycle `reg_we` pulse, with `reg_addr` and `reg_wdata` valid in that cycle.
- R5: A write to an address whose bit in the `WR_MASK` parameter is 0 (by default, addresses 64 to 127) produces no `reg_we`.
- R6: A command with bit 7 = 0 is answered 250 µs after the sample of its last bit. The reply is the byte on `reg_rdata`, least-significant bit first. Each bit starts with a 40 µs pull: a 1 ends there, and a 0 is held low to 120 µs. Bit starts are 205 µs apart.
- R7: If a byte is partly received and no falling edge follows within 1000 µs, the byte is dropped and a new break is needed.
- R8: A low of break length at any point restarts reception, including in the middle of a byte.
- R9: After a complete write or read, the next command is accepted without a new break.
- R10: `bus_pull` is asserted only while a reply is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| bus_in | input | 1 | Level sensed on the bus wire (asynchronous) |
| bus_pull | output | 1 | 1 = pull the open-drain wire low |
| reg_addr | output | 7 | Register address taken from the last command |
| reg_wdata | output | 8 | Data byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr` |

## Verification
The host model sends all-zero, all-one and mixed command and data bytes. Because each byte mixes long and short low pulses, a wrong sample point or a reversed bit order shows up as a wrong address or wrong data in the write scoreboard. Reads of written and unwritten registers check the reply byte, the delay before the reply and the pulse widths, so a wrong level polarity or timer length can be told apart from a wrong value. Further sequences cover traffic with no break, a recovery that is too short, a stalled byte and a break in the middle of a byte. Each of these must leave the block silent until a proper break, which shows that the block resynchronises and does not accept stale bits.

// File: rtl/owire_pkg.sv
package owire_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,   // waiting for a break
    ST_BRK,    // break low in progress
    ST_REC,    // high recovery after break
    ST_CMD,    // receiving command byte
    ST_WDATA,  // receiving write data byte
    ST_GAP,    // delay before reply
    ST_TX      // sending reply
  } ow_state_e;
endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              q_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      q_d   <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      q_d   <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign fall = q_d & ~q;
endmodule

// File: rtl/owire_rx.sv
module owire_rx #(
  parameter int BREAK_US   = 190,
  parameter int REC_US     = 40,
  parameter int SAMPLE_US  = 70,
  parameter int TIMEOUT_US = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic fall,
  input  logic en,
  output logic brk,
  output logic hi_ok,
  output logic idle_to,
  output logic bit_valid,
  output logic bit_val
);
  localparam int CW = $clog2(TIMEOUT_US + 1);

  logic [CW-1:0] low_cnt, high_cnt, idle_cnt, bt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '0;
      idle_cnt <= '0;
    end else begin
      if (line) low_cnt <= '0;
      else if (tick && low_cnt != CW'(BREAK_US)) low_cnt <= low_cnt + 1'b1;
      if (!line) high_cnt <= '0;
      else if (tick && high_cnt != CW'(REC_US)) high_cnt <= high_cnt + 1'b1;
      if (fall) idle_cnt <= '0;
      else if (tick && idle_cnt != CW'(TIMEOUT_US)) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign brk     = (low_cnt == CW'(BREAK_US));
  assign hi_ok   = (high_cnt == CW'(REC_US));
  assign idle_to = (idle_cnt == CW'(TIMEOUT_US));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      bt        <= '0;
      bit_valid <= 1'b0;
      bit_val   <= 1'b0;
    end else if (!en) begin
      run       <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (fall) begin
        run <= 1'b1;
        bt  <= '0;
      end else if (run && tick) begin
        if (bt == CW'(SAMPLE_US - 1)) begin
          run       <= 1'b0;
          bit_valid <= 1'b1;
          bit_val   <= line;
        end else begin
          bt <= bt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/owire_tx.sv
module owire_tx #(
  parameter int LOW_US   = 40,
  parameter int REL_US   = 120,
  parameter int CYCLE_US = 205
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       abort,
  input  logic [7:0] data,
  output logic       pull,
  output logic       done
);
  localparam int TW = $clog2(CYCLE_US + 1);

  logic          active;
  logic [TW-1:0] t;
  logic [2:0]    bi;
  logic [7:0]    sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      t      <= '0;
      bi     <= '0;
      sh     <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
      end else if (start) begin
        active <= 1'b1;
        t      <= '0;
        bi     <= '0;
        sh     <= data;
      end else if (active && tick) begin
        if (t == TW'(CYCLE_US - 1)) begin
          t <= '0;
          if (bi == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bi <= bi + 1'b1;
            sh <= {1'b0, sh[7:1]};
          end
        end else begin
          t <= t + 1'b1;
        end
      end
    end
  end

  assign pull = active & ((t < TW'(LOW_US)) | (~sh[0] & (t < TW'(REL_US))));

  // R6: a pull never lasts longer than the zero-bit hold time
  logic [TW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (!pull) run_len <= '0;
    else if (tick && run_len != TW'(CYCLE_US)) run_len <= run_len + 1'b1;
  end

  a_r6_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= TW'(REL_US));
endmodule

// File: rtl/owire_slave.sv
module owire_slave
  import owire_pkg::*;
#(
  parameter int           BREAK_US    = 190,
  parameter int           REC_US      = 40,
  parameter int           SAMPLE_US   = 70,
  parameter int           TIMEOUT_US  = 1000,
  parameter int           RESP_US     = 250,
  parameter int           TX_LOW_US   = 40,
  parameter int           TX_REL_US   = 120,
  parameter int           TX_CYCLE_US = 205,
  parameter int           SYNC_STAGES = 2,
  parameter logic [127:0] WR_MASK     = {64'h0, {64{1'b1}}}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       bus_in,
  output logic       bus_pull,
  output logic [6:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam int GW = $clog2(RESP_US + 1);

  logic line, fall, brk, hi_ok, idle_to, bit_valid, bit_val;
  logic tx_start, tx_done, rx_en;
  ow_state_e     state;
  logic [7:0]    sh;
  logic [3:0]    nb;
  logic [GW-1:0] gap;
  logic [7:0]    nbyte;

  owire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(line), .fall(fall));

  assign rx_en = (state == ST_CMD) || (state == ST_WDATA);

  owire_rx #(.BREAK_US(BREAK_US), .REC_US(REC_US), .SAMPLE_US(SAMPLE_US),
             .TIMEOUT_US(TIMEOUT_US)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .line(line), .fall(fall),
    .en(rx_en), .brk(brk), .hi_ok(hi_ok), .idle_to(idle_to),
    .bit_valid(bit_valid), .bit_val(bit_val));

  assign tx_start = (state == ST_GAP) && tick_us && (gap == GW'(RESP_US - 1)) && !brk;

  owire_tx #(.LOW_US(TX_LOW_US), .REL_US(TX_REL_US), .CYCLE_US(TX_CYCLE_US)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .start(tx_start), .abort(brk),
    .data(reg_rdata), .pull(bus_pull), .done(tx_done));

  assign nbyte = {bit_val, sh[7:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_HUNT;
      sh        <= '0;
      nb        <= '0;
      gap       <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (brk) begin
        state <= ST_BRK;
        nb    <= '0;
      end else begin
        unique case (state)
          ST_HUNT: ;
          ST_BRK:  if (line) state <= ST_REC;
          ST_REC: begin
            if (fall) state <= ST_HUNT;
            else if (hi_ok) begin
              state <= ST_CMD;
              nb    <= '0;
            end
          end
          ST_CMD, ST_WDATA: begin
            if (bit_valid) begin
              sh <= nbyte;
              if (nb == 4'd7) begin
                nb <= '0;
                if (state == ST_CMD) begin
                  reg_addr <= nbyte[6:0];
                  if (nbyte[7]) state <= ST_WDATA;
                  else begin
                    state <= ST_GAP;
                    gap   <= '0;
                  end
                end else begin
                  reg_wdata <= nbyte;
                  reg_we    <= WR_MASK[reg_addr];
                  state     <= ST_CMD;
                end
              end else begin
                nb <= nb + 1'b1;
              end
            end else if (idle_to && nb != 4'd0) begin
              state <= ST_HUNT;
              nb    <= '0;
            end
          end
          ST_GAP: begin
            if (tx_start) state <= ST_TX;
            else if (tick_us) gap <= gap + 1'b1;
          end
          ST_TX: if (tx_done) state <= ST_CMD;
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  // R10: the wire is pulled only while a reply is in progress
  a_r10_pull_only_tx: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pull |-> state == ST_TX);
  // R4: the write strobe is a single cycle
  a_r4_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  // R4: the address does not move while it is written
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));
  // R1: a write only follows a data byte phase
  a_r1_we_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(state) == ST_WDATA);
endmodule

// File: tb/owire_slave_test.sv
module owire_slave_test;
  logic clk = 0, rst_n = 0, host_low = 0;
  logic bus_pull, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [128];
  wire bus_in = ~(host_low | bus_pull);
  int checks = 0, fails = 0, cyc = 0, last_fall = 0;
  bit rd_window = 0;
  int stray_pull = 0;
  logic [14:0] wq[$];  // {addr, data}

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  owire_slave uut (.clk(clk), .rst_n(rst_n), .tick_us(1'b1), .bus_in(bus_in),
    .bus_pull(bus_pull), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes
  always @(negedge clk) begin
    if (rst_n && bus_pull && !rd_window) stray_pull++;
    if (rst_n && reg_we) begin
      if (wq.size() == 0) check(0, "R1/R5 unexpected write", {reg_addr, reg_wdata}, -1);
      else begin
        logic [14:0] e;
        e = wq.pop_front();
        check({reg_addr, reg_wdata} == e, "R4/R3 write addr+data", {reg_addr, reg_wdata}, e);
      end
      mem[reg_addr] = reg_wdata;
    end
  end

  task automatic wait_us(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    host_low = 1; last_fall = cyc;
    wait_us(b ? 20 : 100);
    host_low = 0;
    wait_us(b ? 180 : 100);
  endtask

  task automatic send_byte(input logic [7:0] x);
    for (int i = 0; i < 8; i++) send_bit(x[i]);
  endtask

  task automatic send_break(input int rec);
    host_low = 1; wait_us(200);
    host_low = 0; wait_us(rec);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input bit expect_we);
    if (expect_we) wq.push_back({a, d});
    send_byte({1'b1, a});
    send_byte(d);
    wait_us(20);
  endtask

  task automatic do_read(input logic [6:0] a, input bit expect_resp, input string tag);
    logic [7:0] exp, got;
    int waited = 0, rise0 = 0, w = 0, dly;
    exp = mem[a];
    send_byte({1'b0, a});
    rd_window = 1;
    while (!bus_pull && waited < 500) begin @(negedge clk); waited++; end
    if (!expect_resp) begin
      check(!bus_pull, {tag, " no reply expected"}, bus_pull, 0);
    end else begin
      dly = cyc - last_fall;
      check(dly >= 314 && dly <= 334, "R6 reply delay", dly, 324);
      for (int i = 0; i < 8; i++) begin
        int guard = 0;
        while (!bus_pull && guard < 400) begin @(negedge clk); guard++; end
        if (i == 1) check((cyc - rise0) >= 204 && (cyc - rise0) <= 206, "R6 bit period", cyc - rise0, 205);
        rise0 = cyc;
        w = 0;
        while (bus_pull && w < 400) begin @(negedge clk); w++; end
        got[i] = (w < 80);
        check((w >= 38 && w <= 42) || (w >= 118 && w <= 122), "R6 pulse width", w, got[i] ? 40 : 120);
      end
      check(got == exp, {tag, " read byte"}, got, exp);
    end
    wait_us(200);
    rd_window = 0;
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3 + 7);
    wait_us(5);
    rst_n = 1;
    wait_us(3);
    check(bus_pull == 0 && reg_we == 0, "R1 reset state", {bus_pull, reg_we}, 0);
    // R1: traffic before any break is ignored
    do_write(7'h05, 8'h11, 0);
    do_read(7'h05, 0, "R1");
    // R2: break with proper recovery, then write and read back (R9: no new break)
    send_break(60);
    do_write(7'h05, 8'hA5, 1);
    do_read(7'h05, 1, "R9 R3");
    // R3: several patterns
    do_write(7'h00, 8'hFF, 1);
    do_write(7'h3F, 8'h00, 1);
    do_write(7'h2A, 8'h5A, 1);
    do_read(7'h2A, 1, "R3");
    do_read(7'h3F, 1, "R3");
    // R5: non-writable address
    do_write(7'h45, 8'hC3, 0);
    do_read(7'h45, 1, "R5");
    // R2: recovery too short
    send_break(20);
    do_write(7'h06, 8'h77, 0);
    do_read(7'h06, 0, "R2");
    send_break(60);
    do_write(7'h06, 8'h77, 1);
    // R7: stalled byte
    send_bit(1); send_bit(0); send_bit(1);
    wait_us(1200);
    do_write(7'h07, 8'h99, 0);
    do_read(7'h07, 0, "R7");
    send_break(60);
    do_write(7'h07, 8'h99, 1);
    // R8: break in middle of a byte
    send_bit(0); send_bit(1); send_bit(1); send_bit(0);
    send_break(60);
    do_write(7'h08, 8'h3C, 1);
    do_read(7'h08, 1, "R8");
    wait_us(50);
    check(wq.size() == 0, "R4 all writes seen", wq.size(), 0);
    check(stray_pull == 0, "R10 no pull outside reply", stray_pull, 0);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule